// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that measures its deadlines against an externally supplied free-running 64-bit system count. It has no counter of its own. It holds an absolute deadline, which is the compare word. Every refresh reloads that deadline as "current count plus offset".

When the count reaches the deadline with no refresh, the block enters its first stage. It raises a level interrupt and arms a second deadline one offset period later. If that second deadline also passes without a refresh, the block enters its second stage. It raises a reset request and records a sticky status bit. Only a power-on reset clears that status bit, so software can still see after the warm reset that the watchdog caused it.

Software reaches the block through two register windows, each a simple synchronous read/write port:
- The kick window holds a single write-to-refresh location.
- The control window holds the control/status word, the offset and the two halves of the deadline.

Top module: `wdt_two_stage`

## Requirements
- R1: After `por_rst`, `stage0_irq` and `stage1_rst_req` are low, and the control word reads 0.
- R2: A write to control address 0x000 sets the enable flag from data bit 0. The same write refreshes the watchdog: the deadline becomes the count plus the offset, and the first-stage flag clears.
- R3: A kick-window write to address 0x000 refreshes the watchdog, whatever the enable state. A refresh in the same cycle as a deadline hit takes priority over that hit.
- R4: A write to address 0x008 replaces the 32-bit offset. It refreshes the watchdog only while the enable flag is set.
- R5: While enabled with the first-stage flag clear, a count at or above the deadline (unsigned comparison) has three effects one cycle later: the first-stage flag sets, `stage0_irq` goes high, and the deadline is reloaded to the count plus the offset.
- R6: While enabled with the first-stage flag set, a count at or above the deadline sets the second-stage flag and raises `stage1_rst_req` one cycle later.
- R7: While the enable flag is clear, the count never changes either stage flag.
- R8: `warm_rst` clears the enable flag, the first-stage flag, the offset, the deadline and `stage1_rst_req`, but keeps the second-stage flag. Only `por_rst` clears the second-stage flag.
- R9: A write to 0x010 replaces the low 32 bits of the deadline, and a write to 0x014 replaces the high 32 bits. Either write clears the first-stage flag.
- R10: Reads return data one cycle after the address. The control word reads bit 0 as enable, bit 1 as first stage and bit 2 as second stage. Offset 0xFCC reads the identification value in both windows. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high, clears everything |
| warm_rst | input | 1 | Synchronous warm reset, active high, keeps the second-stage flag |
| sys_count | input | CNT_W | External free-running system count |
| kick_wr | input | 1 | Kick-window write strobe |
| kick_addr | input | 12 | Kick-window address |
| kick_rdata | output | DATA_W | Kick-window read data, registered |
| ctl_wr | input | 1 | Control-window write strobe |
| ctl_addr | input | 12 | Control-window address |
| ctl_wdata | input | DATA_W | Control-window write data |
| ctl_rdata | output | DATA_W | Control-window read data, registered |
| stage0_irq | output | 1 | First-stage level interrupt |
| stage1_rst_req | output | 1 | Second-stage level reset request |

## Verification
Errors in the deadline register show up at the ports in two ways. The deadline read-back differs from count plus offset on the cycle after a refresh. The interrupt also fires one cycle early or late when the count is placed exactly at, or one below, the deadline.

A first-stage flag that is stuck or dropped shows up directly on `stage0_irq`. It also shows up as a reset request that arrives without a preceding interrupt. A second-stage flag lost to the warm reset is visible at the very next control-word read. Because the bench jumps the count straight to boundary values, every such fault appears within two or three cycles of its trigger.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFFSET  = 12'h008;
  localparam logic [ADDR_W-1:0] A_DL_LO   = 12'h010;
  localparam logic [ADDR_W-1:0] A_DL_HI   = 12'h014;
  localparam logic [ADDR_W-1:0] A_KICK    = 12'h000;
  localparam logic [ADDR_W-1:0] A_IDENT   = 12'hFCC;

  typedef struct packed {
    logic kick;
    logic wr_ctrl;
    logic ctrl_en;
    logic wr_off;
    logic wr_dl_lo;
    logic wr_dl_hi;
  } wdt_evt_t;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 32,
  parameter int CNT_W  = 64,
  parameter logic [DATA_W-1:0] IDENT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_wr,
  input  logic [ADDR_W-1:0] kick_addr,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic              st_en,
  input  logic              st_ws0,
  input  logic              st_ws1,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [CNT_W-1:0]  st_dl,
  output wdt_evt_t          evt,
  output logic [DATA_W-1:0] kick_rdata,
  output logic [DATA_W-1:0] ctl_rdata
);
  localparam int STAT_W = 3;

  logic [STAT_W-1:0] status;
  logic [DATA_W-1:0] ctl_mux;
  logic [DATA_W-1:0] kick_mux;

  assign status = {st_ws1, st_ws0, st_en};

  always_comb begin
    evt          = '0;
    evt.kick     = kick_wr && (kick_addr == A_KICK);
    evt.wr_ctrl  = ctl_wr && (ctl_addr == A_CTRL);
    evt.wr_off   = ctl_wr && (ctl_addr == A_OFFSET);
    evt.wr_dl_lo = ctl_wr && (ctl_addr == A_DL_LO);
    evt.wr_dl_hi = ctl_wr && (ctl_addr == A_DL_HI);
  end

  always_comb begin
    case (ctl_addr)
      A_CTRL:   ctl_mux = DATA_W'(status);
      A_OFFSET: ctl_mux = DATA_W'(st_off);
      A_DL_LO:  ctl_mux = st_dl[DATA_W-1:0];
      A_DL_HI:  ctl_mux = st_dl[CNT_W-1:DATA_W];
      A_IDENT:  ctl_mux = IDENT;
      default:  ctl_mux = '0;
    endcase
    kick_mux = (kick_addr == A_IDENT) ? IDENT : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rdata  <= '0;
      kick_rdata <= '0;
    end else begin
      ctl_rdata  <= ctl_mux;
      kick_rdata <= kick_mux;
    end
  end
endmodule

// File: rtl/wdt_stage_timer.sv
module wdt_stage_timer
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic [CNT_W-1:0]  sys_count,
  input  wdt_evt_t          evt,
  input  logic              ctrl_en_bit,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              ws0_q,
  output logic              ws1_q,
  output logic              rst_req_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [CNT_W-1:0]  dl_q
);
  logic             refresh;
  logic             dl_write;
  logic             hit;
  logic             stage1_hit;
  logic [OFF_W-1:0] off_next;

  assign off_next   = evt.wr_off ? wdata[OFF_W-1:0] : off_q;
  assign refresh    = evt.kick | evt.wr_ctrl | (evt.wr_off & en_q);
  assign dl_write   = evt.wr_dl_lo | evt.wr_dl_hi;
  assign hit        = en_q && (sys_count >= dl_q);
  assign stage1_hit = hit && ws0_q && !refresh && !dl_write;

  always_ff @(posedge clk) begin
    if (por_rst || warm_rst) begin
      en_q      <= 1'b0;
      ws0_q     <= 1'b0;
      rst_req_q <= 1'b0;
      off_q     <= '0;
      dl_q      <= '0;
    end else begin
      off_q <= off_next;
      if (evt.wr_ctrl) en_q <= ctrl_en_bit;
      if (refresh) begin
        dl_q  <= sys_count + CNT_W'(off_next);
        ws0_q <= 1'b0;
      end else if (dl_write) begin
        if (evt.wr_dl_lo) dl_q[DATA_W-1:0]     <= wdata;
        if (evt.wr_dl_hi) dl_q[CNT_W-1:DATA_W] <= wdata;
        ws0_q <= 1'b0;
      end else if (hit) begin
        if (!ws0_q) begin
          ws0_q <= 1'b1;
          dl_q  <= sys_count + CNT_W'(off_q);
        end else begin
          rst_req_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst)         ws1_q <= 1'b0;
    else if (stage1_hit) ws1_q <= 1'b1;
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 32,
  parameter int CNT_W  = 2 * DATA_W,
  parameter logic [DATA_W-1:0] IDENT = 32'h0002_1A5B
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              kick_wr,
  input  logic [11:0]       kick_addr,
  output logic [DATA_W-1:0] kick_rdata,
  input  logic              ctl_wr,
  input  logic [11:0]       ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              stage0_irq,
  output logic              stage1_rst_req
);
  wdt_evt_t         evt;
  logic             en_q;
  logic             ws0_q;
  logic             ws1_q;
  logic             rst_req_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] dl_q;

  wdt_regif #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .IDENT(IDENT)
  ) u_regif (
    .clk        (clk),
    .rst        (por_rst | warm_rst),
    .kick_wr    (kick_wr),
    .kick_addr  (kick_addr),
    .ctl_wr     (ctl_wr),
    .ctl_addr   (ctl_addr),
    .st_en      (en_q),
    .st_ws0     (ws0_q),
    .st_ws1     (ws1_q),
    .st_off     (off_q),
    .st_dl      (dl_q),
    .evt        (evt),
    .kick_rdata (kick_rdata),
    .ctl_rdata  (ctl_rdata)
  );

  wdt_stage_timer #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk         (clk),
    .por_rst     (por_rst),
    .warm_rst    (warm_rst),
    .sys_count   (sys_count),
    .evt         (evt),
    .ctrl_en_bit (ctl_wdata[0]),
    .wdata       (ctl_wdata),
    .en_q        (en_q),
    .ws0_q       (ws0_q),
    .ws1_q       (ws1_q),
    .rst_req_q   (rst_req_q),
    .off_q       (off_q),
    .dl_q        (dl_q)
  );

  assign stage0_irq     = ws0_q;
  assign stage1_rst_req = rst_req_q;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic        clk,
  input logic        por_rst,
  input logic        warm_rst,
  input logic        kick_wr,
  input logic [11:0] kick_addr,
  input logic        wd_irq,
  input logic        wd_rst,
  input logic        st_en,
  input logic        st_ws1
);
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    $rose(wd_irq) |-> $past(st_en));

  p_rst_after_irq_r6: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    $rose(wd_rst) |-> ($past(wd_irq) && $past(st_en)));

  p_ws1_sticky_r8: assert property (@(posedge clk) disable iff (por_rst)
    st_ws1 |=> st_ws1);

  p_warm_clears_r8: assert property (@(posedge clk) disable iff (por_rst)
    warm_rst |=> (!wd_rst && !wd_irq));

  p_kick_clears_r3: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (kick_wr && kick_addr == 12'h000) |=> !wd_irq);
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk       (clk),
  .por_rst   (por_rst),
  .warm_rst  (warm_rst),
  .kick_wr   (kick_wr),
  .kick_addr (kick_addr),
  .wd_irq    (stage0_irq),
  .wd_rst    (stage1_rst_req),
  .st_en     (en_q),
  .st_ws1    (ws1_q)
);

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
  localparam logic [31:0] ID = 32'h0002_1A5B;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic [63:0] sys_count = '0;
  logic        kick_wr = 1'b0;
  logic [11:0] kick_addr = '0;
  logic [31:0] kick_rdata;
  logic        ctl_wr = 1'b0;
  logic [11:0] ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        stage0_irq;
  logic        stage1_rst_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_two_stage #(.IDENT(ID)) u0 (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .sys_count(sys_count),
    .kick_wr(kick_wr), .kick_addr(kick_addr), .kick_rdata(kick_rdata),
    .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stage0_irq(stage0_irq), .stage1_rst_req(stage1_rst_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [11:0] a, input logic [31:0] d);
    ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_ctl(input logic [11:0] a, output logic [31:0] d);
    ctl_addr = a;
    @(negedge clk);
    d = ctl_rdata;
  endtask

  task automatic kick(input logic [11:0] a);
    kick_wr = 1'b1; kick_addr = a;
    @(negedge clk);
    kick_wr = 1'b0; kick_addr = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_por();
    por_rst = 1'b1; step(2); por_rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_por();
    chk("R1 irq after por", stage0_irq, 0);
    chk("R1 rst_req after por", stage1_rst_req, 0);
    rd_ctl(12'h000, d); chk("R1 control word", d, 0);
    rd_ctl(12'hFCC, d); chk("R10 ident control window", d, ID);
    kick_addr = 12'hFCC; step(1);
    chk("R10 ident kick window", kick_rdata, ID);
    kick_addr = 12'h000;
    rd_ctl(12'h020, d); chk("R10 unmapped reads zero", d, 0);
  endtask

  task automatic t_stage_flow();
    logic [31:0] d;
    wr_ctl(12'h008, 32'd100);
    rd_ctl(12'h010, d); chk("R4 offset write while disabled no refresh", d, 0);
    rd_ctl(12'h008, d); chk("R4 offset readback", d, 100);
    sys_count = 64'd1000;
    wr_ctl(12'h000, 32'h1);
    rd_ctl(12'h010, d); chk("R2 deadline lo after enable", d, 1100);
    rd_ctl(12'h014, d); chk("R2 deadline hi after enable", d, 0);
    rd_ctl(12'h000, d); chk("R10 control enable bit", d, 1);
    sys_count = 64'd1099; step(3);
    chk("R5 no irq one below deadline", stage0_irq, 0);
    sys_count = 64'd1100; step(1);
    chk("R5 irq at deadline", stage0_irq, 1);
    rd_ctl(12'h010, d); chk("R5 deadline reloaded", d, 1200);
    rd_ctl(12'h000, d); chk("R10 control first stage", d, 3);
    sys_count = 64'd1199; step(3);
    chk("R6 no reset one below second deadline", stage1_rst_req, 0);
    sys_count = 64'd1200; step(1);
    chk("R6 reset request at second deadline", stage1_rst_req, 1);
    rd_ctl(12'h000, d); chk("R6 control second stage", d, 7);
  endtask

  task automatic t_warm();
    logic [31:0] d;
    warm_rst = 1'b1; step(1); warm_rst = 1'b0;
    chk("R8 warm clears rst_req", stage1_rst_req, 0);
    chk("R8 warm clears irq", stage0_irq, 0);
    rd_ctl(12'h000, d); chk("R8 second stage survives warm", d, 4);
    rd_ctl(12'h008, d); chk("R8 warm clears offset", d, 0);
    do_por();
    rd_ctl(12'h000, d); chk("R8 por clears second stage", d, 0);
  endtask

  task automatic t_refresh();
    logic [31:0] d;
    wr_ctl(12'h008, 32'd50);
    sys_count = 64'd500;
    wr_ctl(12'h000, 32'h1);
    sys_count = 64'd549;
    kick(12'h000);
    rd_ctl(12'h010, d); chk("R3 kick reloads deadline", d, 599);
    sys_count = 64'd598; step(2);
    chk("R3 no irq after kick", stage0_irq, 0);
    sys_count = 64'd599; step(1);
    chk("R5 irq after kick deadline", stage0_irq, 1);
    sys_count = 64'd620;
    kick(12'h000);
    chk("R3 kick clears irq", stage0_irq, 0);
    sys_count = 64'd700;
    kick(12'h000);
    chk("R3 kick wins over hit", stage0_irq, 0);
    rd_ctl(12'h010, d); chk("R3 deadline after priority kick", d, 750);
    sys_count = 64'd800;
    wr_ctl(12'h008, 32'd30);
    rd_ctl(12'h010, d); chk("R4 offset write refreshes when enabled", d, 830);
  endtask

  task automatic t_deadline_write();
    logic [31:0] d;
    sys_count = 64'd830; step(1);
    chk("R5 irq before deadline write", stage0_irq, 1);
    wr_ctl(12'h010, 32'd5000);
    chk("R9 deadline write clears irq", stage0_irq, 0);
    rd_ctl(12'h010, d); chk("R9 deadline lo written", d, 5000);
    wr_ctl(12'h014, 32'd1);
    rd_ctl(12'h014, d); chk("R9 deadline hi written", d, 1);
    sys_count = 64'd5000; step(2);
    chk("R9 high word honoured", stage0_irq, 0);
    sys_count = 64'h8000_0000_0000_0000; step(1);
    chk("R5 unsigned compare fires", stage0_irq, 1);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr_ctl(12'h000, 32'h0);
    chk("R2 disable write clears irq", stage0_irq, 0);
    sys_count = '1; step(4);
    chk("R7 no irq while disabled", stage0_irq, 0);
    chk("R7 no reset while disabled", stage1_rst_req, 0);
    rd_ctl(12'h000, d); chk("R7 control word stays clear", d, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_stage_flow();
    t_warm();
    t_refresh();
    t_deadline_write();
    t_disabled();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule